// File: doc/BRIEF.md
# Received Pause Frame Filter

This block sits behind the receive parser of an Ethernet MAC and judges each MAC control frame after its fields have been pulled out of the byte stream. For every frame strobe it reports two results one cycle later. The first is whether the frame is handed on to the client or dropped. The second is whether a pause notification goes to the transmit side, listing the priority classes to stop and the 16-bit pause time for each of them.

A frame is acted on only when it is flagged as a pause frame and its destination address equals a programmable 48-bit match address. Each priority class has its own enable bit that gates the notification. When the block is built with a single class (standard flow control), a separate transmit honour bit must also be set before a notification is raised. Matching pause frames reach the client only when the forward bit is set. Every other frame is always delivered.

All configuration inputs are copied into a shadow register in cycles that carry no frame strobe. A frame is therefore always judged against one consistent set of settings, and a change made in the same cycle as a strobe applies from the next frame.

Top module: `pause_rx_filter`

## Requirements
- R1: After reset, the shadow settings are: match address 48'h0180_C200_0001 (high 16 bits 16'h0180, low 32 bits 32'hC200_0001), every class enable at 1, forward bit 0 and honour bit 0. Both output strobes are low while reset is held.
- R2: The match address is {cfg_addr_hi, cfg_addr_lo}. A pause frame whose destination equals it, and whose class vector has at least one enabled bit, raises `pn_valid` in the cycle after `frm_valid`, with `pn_class` = `frm_class_vec` AND the enables. A destination that differs in any bit produces no notification.
- R3: A class whose enable bit is 0 is never signalled. If no class is left after the enables are applied, `pn_valid` stays low.
- R4: For each signalled class n, `pn_time[16n+15:16n]` carries that class's slot of `frm_pause_time`. The slots of unsignalled classes are zero.
- R5: `pn_valid` is high for exactly one cycle per processed frame and is low in the cycle after a cycle without a strobe.
- R6: Every frame strobe gives `fwd_valid` one cycle later. `fwd_keep` is 1 for non-pause frames and for pause frames whose address does not match. For matching pause frames `fwd_keep` equals the forward bit.
- R7: A frame with `frm_is_pause` = 0 never raises `pn_valid`.
- R8: With NUM_CLASSES = 1, a notification is raised only while the shadowed honour bit is 1. Forwarding is unaffected by that bit.
- R9: Settings that change in the same cycle as `frm_valid` do not affect that frame and apply to the next frame that follows a cycle without a strobe.
- R10: Any 48-bit value is accepted as the match address, including broadcast (all ones) and unicast values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr_hi | input | 16 | Upper 16 bits of the match address |
| cfg_addr_lo | input | 32 | Lower 32 bits of the match address |
| cfg_class_en | input | NUM_CLASSES | Per-class processing enables |
| cfg_fwd_match | input | 1 | Deliver matching pause frames to the client |
| cfg_tx_honour | input | 1 | Transmit honour bit, used only when NUM_CLASSES is 1 |
| frm_valid | input | 1 | One-cycle strobe marking a parsed frame |
| frm_is_pause | input | 1 | Frame is a MAC control pause frame |
| frm_dst_addr | input | 48 | Destination address of the frame |
| frm_class_vec | input | NUM_CLASSES | Classes named in the frame |
| frm_pause_time | input | NUM_CLASSES*16 | Pause time per class, class n in bits [16n+15:16n] |
| pn_valid | output | 1 | Pause notification strobe to the transmit side |
| pn_class | output | NUM_CLASSES | Classes to pause |
| pn_time | output | NUM_CLASSES*16 | Pause time per signalled class, zero elsewhere |
| fwd_valid | output | 1 | Delivery decision strobe |
| fwd_keep | output | 1 | 1 = deliver frame to the client, 0 = drop |

## Verification
The assertions rely on two conditions on the inputs: `frm_valid` is low while reset is held, and it is a strobe whose companion fields are valid in the same cycle. The stimulus drives every input on the falling edge. It leaves a strobe-free cycle before each tabled frame so that fresh settings are shadowed, and it breaks that pattern only on purpose, in the same-cycle configuration case and in the back-to-back frame case. The single-class build gets its own instance so that the honour gating is checked at its ports.

// File: rtl/pause_filt_pkg.sv
package pause_filt_pkg;
    localparam int ADDR_W  = 48;
    localparam int QUANTA_W = 16;
    localparam logic [ADDR_W-1:0] MATCH_ADDR_RST = 48'h0180_C200_0001;
endpackage

// File: rtl/pause_cfg_shadow.sv
module pause_cfg_shadow
    import pause_filt_pkg::*;
#(
    parameter int NUM_CLASSES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   hold,
    input  logic [15:0]            addr_hi,
    input  logic [31:0]            addr_lo,
    input  logic [NUM_CLASSES-1:0] class_en,
    input  logic                   fwd_match,
    input  logic                   tx_honour,
    output logic [ADDR_W-1:0]      sh_addr,
    output logic [NUM_CLASSES-1:0] sh_en,
    output logic                   sh_fwd,
    output logic                   sh_honour
);
    typedef struct packed {
        logic [ADDR_W-1:0]      addr;
        logic [NUM_CLASSES-1:0] en;
        logic                   fwd;
        logic                   honour;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (!hold) begin
            sh_d.addr   = {addr_hi, addr_lo};
            sh_d.en     = class_en;
            sh_d.fwd    = fwd_match;
            sh_d.honour = tx_honour;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q.addr   <= MATCH_ADDR_RST;
            sh_q.en     <= '1;
            sh_q.fwd    <= 1'b0;
            sh_q.honour <= 1'b0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign sh_addr   = sh_q.addr;
    assign sh_en     = sh_q.en;
    assign sh_fwd    = sh_q.fwd;
    assign sh_honour = sh_q.honour;

    // R9: a strobe cycle freezes the shadowed settings
    p_hold_freezes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(sh_q));
endmodule

// File: rtl/pause_addr_cmp.sv
module pause_addr_cmp
    import pause_filt_pkg::*;
(
    input  logic [ADDR_W-1:0] frame_addr,
    input  logic [ADDR_W-1:0] ref_addr,
    output logic              equal
);
    assign equal = (frame_addr == ref_addr);
endmodule

// File: rtl/pause_class_sel.sv
module pause_class_sel
    import pause_filt_pkg::*;
#(
    parameter int NUM_CLASSES = 8
) (
    input  logic [NUM_CLASSES-1:0]          sel,
    input  logic [NUM_CLASSES*QUANTA_W-1:0] time_in,
    output logic [NUM_CLASSES*QUANTA_W-1:0] time_out
);
    for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_slot
        assign time_out[i*QUANTA_W +: QUANTA_W] =
            sel[i] ? time_in[i*QUANTA_W +: QUANTA_W] : '0;
    end
endmodule

// File: rtl/pause_rx_filter.sv
module pause_rx_filter
    import pause_filt_pkg::*;
#(
    parameter int NUM_CLASSES = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [15:0]                     cfg_addr_hi,
    input  logic [31:0]                     cfg_addr_lo,
    input  logic [NUM_CLASSES-1:0]          cfg_class_en,
    input  logic                            cfg_fwd_match,
    input  logic                            cfg_tx_honour,
    input  logic                            frm_valid,
    input  logic                            frm_is_pause,
    input  logic [ADDR_W-1:0]               frm_dst_addr,
    input  logic [NUM_CLASSES-1:0]          frm_class_vec,
    input  logic [NUM_CLASSES*QUANTA_W-1:0] frm_pause_time,
    output logic                            pn_valid,
    output logic [NUM_CLASSES-1:0]          pn_class,
    output logic [NUM_CLASSES*QUANTA_W-1:0] pn_time,
    output logic                            fwd_valid,
    output logic                            fwd_keep
);
    localparam bit SINGLE_CLASS = (NUM_CLASSES == 1);
    localparam int TIME_W = NUM_CLASSES * QUANTA_W;

    typedef struct packed {
        logic                   pn_valid;
        logic [NUM_CLASSES-1:0] pn_class;
        logic [TIME_W-1:0]      pn_time;
        logic                   fwd_valid;
        logic                   fwd_keep;
    } out_t;

    out_t out_d, out_q;

    logic [ADDR_W-1:0]      sh_addr;
    logic [NUM_CLASSES-1:0] sh_en;
    logic                   sh_fwd;
    logic                   sh_honour;
    logic                   addr_eq;
    logic [NUM_CLASSES-1:0] sel;
    logic [TIME_W-1:0]      sel_time;
    logic                   honour_gate;
    logic                   is_match;
    logic                   do_notify;

    pause_cfg_shadow #(.NUM_CLASSES(NUM_CLASSES)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (frm_valid),
        .addr_hi   (cfg_addr_hi),
        .addr_lo   (cfg_addr_lo),
        .class_en  (cfg_class_en),
        .fwd_match (cfg_fwd_match),
        .tx_honour (cfg_tx_honour),
        .sh_addr   (sh_addr),
        .sh_en     (sh_en),
        .sh_fwd    (sh_fwd),
        .sh_honour (sh_honour)
    );

    pause_addr_cmp u_cmp (
        .frame_addr (frm_dst_addr),
        .ref_addr   (sh_addr),
        .equal      (addr_eq)
    );

    assign sel = frm_class_vec & sh_en;

    pause_class_sel #(.NUM_CLASSES(NUM_CLASSES)) u_sel (
        .sel      (sel),
        .time_in  (frm_pause_time),
        .time_out (sel_time)
    );

    generate
        if (SINGLE_CLASS) begin : g_std
            assign honour_gate = sh_honour;
        end else begin : g_prio
            assign honour_gate = 1'b1;
        end
    endgenerate

    assign is_match  = frm_is_pause & addr_eq;
    assign do_notify = frm_valid & is_match & (|sel) & honour_gate;

    always_comb begin
        out_d           = '0;
        out_d.fwd_valid = frm_valid;
        out_d.fwd_keep  = frm_valid & (!is_match | sh_fwd);
        if (do_notify) begin
            out_d.pn_valid = 1'b1;
            out_d.pn_class = sel;
            out_d.pn_time  = sel_time;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pn_valid  = out_q.pn_valid;
    assign pn_class  = out_q.pn_class;
    assign pn_time   = out_q.pn_time;
    assign fwd_valid = out_q.fwd_valid;
    assign fwd_keep  = out_q.fwd_keep;

    // R6: each strobe yields a delivery decision one cycle later
    p_fwd_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> fwd_valid);
    // R5: a notification always traces back to a strobe one cycle earlier
    p_notify_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pn_valid |-> $past(frm_valid));
    // R7: only pause frames notify
    p_pause_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pn_valid |-> $past(frm_is_pause));
    // R3: a notification names at least one class, all of them enabled
    p_class_enabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pn_valid |-> (pn_class != '0) && ((pn_class & ~$past(sh_en)) == '0));
    // R6: a drop happens only for a pause frame
    p_drop_pause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && !fwd_keep) |-> $past(frm_is_pause));

    for (genvar i = 0; i < NUM_CLASSES; i++) begin : g_chk
        // R4: unsignalled slots carry zero
        p_slot_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !pn_class[i] |-> (pn_time[i*QUANTA_W +: QUANTA_W] == '0));
    end

    if (SINGLE_CLASS) begin : g_std_chk
        // R8: in single-class builds notification requires the honour bit
        p_honour_r8: assert property (@(posedge clk) disable iff (!rst_n)
            pn_valid |-> $past(sh_honour));
    end
endmodule

// File: tb/pause_rx_filter_bench.sv
module pause_rx_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 8;
    localparam logic [47:0] DEF_ADDR = 48'h0180_C200_0001;
    localparam logic [47:0] UNI_ADDR = 48'h0011_2233_4455;

    typedef struct packed {
        logic [47:0] cfg_addr;
        logic [7:0]  en;
        logic        fwd;
        logic [47:0] frm_addr;
        logic        pause;
        logic [7:0]  cls;
        logic        exp_pv;
        logic [7:0]  exp_cls;
        logic        exp_keep;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{DEF_ADDR, 8'hFF, 1'b0, DEF_ADDR, 1'b1, 8'h01, 1'b1, 8'h01, 1'b0},
        '{DEF_ADDR, 8'hF0, 1'b0, DEF_ADDR, 1'b1, 8'h0F, 1'b0, 8'h00, 1'b0},
        '{DEF_ADDR, 8'h0F, 1'b0, DEF_ADDR, 1'b1, 8'h3C, 1'b1, 8'h0C, 1'b0},
        '{DEF_ADDR, 8'hFF, 1'b1, DEF_ADDR, 1'b1, 8'h80, 1'b1, 8'h80, 1'b1},
        '{DEF_ADDR, 8'hFF, 1'b0, 48'h0180_C200_0000, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b1},
        '{DEF_ADDR, 8'hFF, 1'b0, DEF_ADDR, 1'b0, 8'hFF, 1'b0, 8'h00, 1'b1},
        '{48'hFFFF_FFFF_FFFF, 8'hFF, 1'b0, 48'hFFFF_FFFF_FFFF, 1'b1, 8'hAA, 1'b1, 8'hAA, 1'b0},
        '{UNI_ADDR, 8'hFF, 1'b0, DEF_ADDR, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b1},
        '{UNI_ADDR, 8'hFF, 1'b0, UNI_ADDR, 1'b1, 8'hFF, 1'b1, 8'hFF, 1'b0},
        '{DEF_ADDR, 8'h00, 1'b0, DEF_ADDR, 1'b1, 8'hFF, 1'b0, 8'h00, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [15:0] cfg_addr_hi;
    logic [31:0] cfg_addr_lo;
    logic [NC-1:0] cfg_class_en;
    logic cfg_fwd_match, cfg_tx_honour;
    logic frm_valid, frm_is_pause;
    logic [47:0] frm_dst_addr;
    logic [NC-1:0] frm_class_vec;
    logic [NC*16-1:0] frm_pause_time;
    logic pn_valid, fwd_valid, fwd_keep;
    logic [NC-1:0] pn_class;
    logic [NC*16-1:0] pn_time;

    pause_rx_filter #(.NUM_CLASSES(NC)) u_pause_rx_filter (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr_hi(cfg_addr_hi), .cfg_addr_lo(cfg_addr_lo),
        .cfg_class_en(cfg_class_en), .cfg_fwd_match(cfg_fwd_match),
        .cfg_tx_honour(cfg_tx_honour),
        .frm_valid(frm_valid), .frm_is_pause(frm_is_pause),
        .frm_dst_addr(frm_dst_addr), .frm_class_vec(frm_class_vec),
        .frm_pause_time(frm_pause_time),
        .pn_valid(pn_valid), .pn_class(pn_class), .pn_time(pn_time),
        .fwd_valid(fwd_valid), .fwd_keep(fwd_keep)
    );

    logic s_honour, s_valid, s_pn_valid, s_fwd_valid, s_fwd_keep;
    logic [0:0] s_pn_class;
    logic [15:0] s_pn_time;

    pause_rx_filter #(.NUM_CLASSES(1)) u_pause_rx_filter_std (
        .clk(clk), .rst_n(rst_n),
        .cfg_addr_hi(16'h0180), .cfg_addr_lo(32'hC200_0001),
        .cfg_class_en(1'b1), .cfg_fwd_match(1'b0),
        .cfg_tx_honour(s_honour),
        .frm_valid(s_valid), .frm_is_pause(1'b1),
        .frm_dst_addr(DEF_ADDR), .frm_class_vec(1'b1),
        .frm_pause_time(16'h0BEE),
        .pn_valid(s_pn_valid), .pn_class(s_pn_class), .pn_time(s_pn_time),
        .fwd_valid(s_fwd_valid), .fwd_keep(s_fwd_keep)
    );

    int checks = 0;
    int fails = 0;

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [NC*16-1:0] times_for(input logic [15:0] base);
        logic [NC*16-1:0] t;
        for (int i = 0; i < NC; i++) t[i*16 +: 16] = base + 16'(i);
        return t;
    endfunction

    function automatic logic [NC*16-1:0] masked(input logic [NC*16-1:0] t, input logic [NC-1:0] m);
        logic [NC*16-1:0] r;
        for (int i = 0; i < NC; i++) r[i*16 +: 16] = m[i] ? t[i*16 +: 16] : 16'h0;
        return r;
    endfunction

    task automatic set_cfg(input logic [47:0] a, input logic [NC-1:0] en, input logic fwd);
        cfg_addr_hi  = a[47:32];
        cfg_addr_lo  = a[31:0];
        cfg_class_en = en;
        cfg_fwd_match = fwd;
    endtask

    task automatic set_frame(input logic [47:0] a, input logic p, input logic [NC-1:0] c,
                             input logic [NC*16-1:0] t);
        frm_valid = 1'b1;
        frm_is_pause = p;
        frm_dst_addr = a;
        frm_class_vec = c;
        frm_pause_time = t;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [NC*16-1:0] tm;
        set_cfg(UNI_ADDR, 8'h00, 1'b1);
        cfg_tx_honour = 1'b0;
        frm_valid = 1'b0; frm_is_pause = 1'b0; frm_dst_addr = '0;
        frm_class_vec = '0; frm_pause_time = '0;
        s_honour = 1'b0; s_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R1: strobes low during reset
        chk("R1 pn_valid in reset", 128'(pn_valid), 128'(0));
        chk("R1 fwd_valid in reset", 128'(fwd_valid), 128'(0));

        // R1: first frame after reset is judged with reset settings, not the inputs
        rst_n = 1'b1;
        tm = times_for(16'h7700);
        set_frame(DEF_ADDR, 1'b1, 8'h01, tm);
        @(negedge clk);
        frm_valid = 1'b0;
        chk("R1 reset address/enable notify", 128'(pn_valid), 128'(1));
        chk("R1 reset forward bit drops", 128'({fwd_valid, fwd_keep}), 128'(2'b10));

        // table walk
        for (int v = 0; v < NV; v++) begin
            set_cfg(VECS[v].cfg_addr, VECS[v].en, VECS[v].fwd);
            @(negedge clk);
            tm = times_for(16'((v + 1) * 256));
            set_frame(VECS[v].frm_addr, VECS[v].pause, VECS[v].cls, tm);
            @(negedge clk);
            frm_valid = 1'b0;
            chk($sformatf("R2/R3/R7/R10 vec%0d pn_valid", v), 128'(pn_valid), 128'(VECS[v].exp_pv));
            chk($sformatf("R2/R3 vec%0d pn_class", v), 128'(pn_class),
                128'(VECS[v].exp_pv ? VECS[v].exp_cls : 8'h00));
            chk($sformatf("R4 vec%0d pn_time", v), 128'(pn_time),
                128'(VECS[v].exp_pv ? masked(tm, VECS[v].exp_cls) : '0));
            chk($sformatf("R6 vec%0d fwd", v), 128'({fwd_valid, fwd_keep}),
                128'({1'b1, VECS[v].exp_keep}));
        end

        // R5: idle cycle after a processed frame leaves both strobes low
        @(negedge clk);
        chk("R5 no notify without strobe", 128'({pn_valid, fwd_valid}), 128'(0));

        // R5: back-to-back frames each notify once
        set_cfg(DEF_ADDR, 8'hFF, 1'b0);
        @(negedge clk);
        set_frame(DEF_ADDR, 1'b1, 8'h02, times_for(16'h0100));
        @(negedge clk);
        chk("R5 back-to-back first", 128'({pn_valid, pn_class}), 128'({1'b1, 8'h02}));
        set_frame(DEF_ADDR, 1'b1, 8'h04, times_for(16'h0200));
        @(negedge clk);
        frm_valid = 1'b0;
        chk("R5 back-to-back second", 128'({pn_valid, pn_class}), 128'({1'b1, 8'h04}));
        @(negedge clk);
        chk("R5 strobe drops after frames", 128'(pn_valid), 128'(0));

        // R9: settings changed with the strobe do not apply to that frame
        set_cfg(UNI_ADDR, 8'hFF, 1'b1);
        set_frame(DEF_ADDR, 1'b1, 8'h10, times_for(16'h0300));
        @(negedge clk);
        frm_valid = 1'b0;
        chk("R9 old address used", 128'({pn_valid, fwd_keep}), 128'({1'b1, 1'b0}));
        @(negedge clk);
        set_frame(DEF_ADDR, 1'b1, 8'h10, times_for(16'h0300));
        @(negedge clk);
        frm_valid = 1'b0;
        chk("R9 new address applies next frame", 128'({pn_valid, fwd_keep}), 128'({1'b0, 1'b1}));

        // R8: single-class build gated by the honour bit
        s_honour = 1'b0;
        @(negedge clk);
        s_valid = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        chk("R8 honour off no notify", 128'(s_pn_valid), 128'(0));
        chk("R8 honour off still drops match", 128'({s_fwd_valid, s_fwd_keep}), 128'(2'b10));
        s_honour = 1'b1;
        @(negedge clk);
        s_valid = 1'b1;
        @(negedge clk);
        s_valid = 1'b0;
        chk("R8 honour on notify", 128'({s_pn_valid, s_pn_class, s_pn_time}),
            128'({1'b1, 1'b1, 16'h0BEE}));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule